// File: doc/BRIEF.md
# Descriptor-Driven Video Fetch Engine

This block is a single-channel fetch engine for a video DMA. A start pulse hands it the address of a descriptor. The engine reads that descriptor from memory and then issues data read requests for the pixel bytes the descriptor describes. Each descriptor selects one of two walks:

- **Line walk.** Fixed-size lines are read, and the source address advances by a stride after each line.
- **Fragment gather.** Up to five scattered source addresses are read. Each one runs only to the next fragment-size boundary.

After the data, the engine can write the descriptor back with its done flag set, and it can raise a completion bit. It then either follows the chain to the next descriptor or stops.

Events are recorded in a sticky status register that software clears by writing ones. The positions of the completion and error bits depend on the channel index parameter. A separate vsync input sets its own bit. The interrupt line is the OR of the status bits that the enable mask lets through. When a run ends, a one-cycle done strobe reports the total bytes moved, or zero if the run ended on an error.

The memory side is one request channel. A request stays asserted, with stable fields, until the memory acknowledges it. The acknowledge can carry an error flag. Each descriptor moves as a single access of the full descriptor word.

Top module: `vdma_fetch`

## Requirements
- R1: After reset, mem_req_o, busy_o, done_o, irq_o and status_o are all 0.
- R2: When descriptor flag bit 0 is 0 (line walk), data reads are issued at src0, src0+stride, src0+2*stride and so on. Each read is line_size bytes long. Mode encoding: mem_op_o is 0 for a descriptor read, 1 for a data read and 2 for a descriptor write.
- R3: The last line or fragment is cut so that the bytes moved never exceed the transfer length. A transfer length of 0, or a line size of 0 in line-walk mode, issues no data reads.
- R4: When flag bit 0 is 1 (fragment gather), data reads use src0, src1 and so on in order. Each read has length FRAG_SZ minus (address modulo FRAG_SZ).
- R5: Fragment gather stops after at most five fragments, even if transfer length remains.
- R6: An acknowledge that carries mem_err_i does four things: it sets status bit 12+CHANNEL, ends the run with done_bytes_o = 0, skips the write-back and leaves the completion bit untouched.
- R7: When flag bit 2 (update) is set, the descriptor is written back to its fetch address after its data, with flag bit 4 (done) set and every other field unchanged.
- R8: When flag bit 1 (completion interrupt) is set, status bit CHANNEL is set when the descriptor finishes.
- R9: A vsync_i pulse sets status bit 27.
- R10: Descriptors are followed through the next-address field until one has flag bit 3 (last) set. If one_desc_i was high at start, the run stops after the first descriptor.
- R11: Writing to the status register clears each bit written as 1. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R12: irq_o is the OR of status bits ANDed with the mask register. The mask resets to all ones.
- R13: At the end of a run, done_o pulses for one cycle with done_bytes_o equal to the sum of bytes moved over all descriptors in the run. While a request waits for its acknowledge, its op and address are held.

Descriptor layout (packed word, LSB first): flags[4:0], transfer length 16, line size 16, line stride 16, src0..src4 at 32 bits each, next address 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a run (accepted when idle) |
| start_addr_i | input | 32 | Address of the first descriptor |
| one_desc_i | input | 1 | Stop after the first descriptor |
| vsync_i | input | 1 | Vsync event pulse |
| sts_wr_i | input | 1 | Status clear write strobe |
| sts_wdata_i | input | 32 | Status bits to clear (ones clear) |
| mask_wr_i | input | 1 | Interrupt mask write strobe |
| mask_wdata_i | input | 32 | New interrupt mask |
| mem_req_o | output | 1 | Memory request valid |
| mem_op_o | output | 2 | 0 descriptor read, 1 data read, 2 descriptor write |
| mem_addr_o | output | 32 | Request address |
| mem_len_o | output | 16 | Data read length in bytes (0 for descriptor ops) |
| mem_wdesc_o | output | 245 | Descriptor word for write-back |
| mem_ack_i | input | 1 | Request accepted and completed |
| mem_err_i | input | 1 | Access failed (valid with ack) |
| mem_rdesc_i | input | 245 | Descriptor word returned on a read |
| status_o | output | 32 | Sticky status register |
| irq_o | output | 1 | Interrupt output |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| done_bytes_o | output | 32 | Bytes moved in the run, 0 on error |

## Verification
The line walk is driven with a length that is not a multiple of the line size. This separates correct stride stepping from correct truncation of the last line. Three gather patterns are used:

- a first address just below a boundary, to check the short first fragment;
- a mid-fragment length cut;
- five fragments with length still left over, to check the five-fragment stop.

A two-descriptor chain is run twice, once with and once without the one-descriptor input. This checks that the next-address field is followed and that the stop input overrides it. An error injected on the second data read must suppress both write-back and completion. The vsync and clear write tests, with a partial mask, separate the sticky set, the write-one-to-clear rule, set-over-clear priority and the masking of the interrupt.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int TOT_W  = 32;
    localparam int STS_W  = 32;
    localparam int NFRAG  = 5;
    localparam int FIDX_W = $clog2(NFRAG + 1);

    typedef enum logic [1:0] {
        OP_DESC_RD = 2'd0,
        OP_DATA_RD = 2'd1,
        OP_DESC_WR = 2'd2
    } mem_op_e;

    typedef struct packed {
        logic done_f;
        logic last_f;
        logic upd_f;
        logic irq_f;
        logic frag_f;
    } dflags_t;

    typedef struct packed {
        logic [ADDR_W-1:0]            next;
        logic [NFRAG-1:0][ADDR_W-1:0] src;
        logic [LEN_W-1:0]             stride;
        logic [LEN_W-1:0]             line_size;
        logic [LEN_W-1:0]             xfer_len;
        dflags_t                      flags;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/vdma_chunk_calc.sv
module vdma_chunk_calc
    import vdma_pkg::*;
#(
    parameter int FRAG_SZ = 4096,
    localparam int FRAG_LG = $clog2(FRAG_SZ)
) (
    input  logic               frag_mode,
    input  logic [FRAG_LG-1:0] addr_lo,
    input  logic [LEN_W-1:0]   line_size,
    input  logic [LEN_W-1:0]   remaining,
    output logic [LEN_W-1:0]   chunk
);
    logic [LEN_W-1:0] base;

    always_comb begin
        if (frag_mode) base = LEN_W'(FRAG_SZ) - LEN_W'(addr_lo);
        else           base = line_size;
        chunk = (base < remaining) ? base : remaining;
    end
endmodule

// File: rtl/vdma_irq_status.sv
module vdma_irq_status
    import vdma_pkg::*;
#(
    parameter int CMPL_BIT  = 0,
    parameter int ERR_BIT   = 12,
    parameter int VSYNC_BIT = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_cmpl,
    input  logic             set_err,
    input  logic             set_vsync,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_data,
    input  logic             mask_we,
    input  logic [STS_W-1:0] mask_data,
    output logic [STS_W-1:0] status,
    output logic             irq
);
    logic [STS_W-1:0] sts_d, sts_q, mask_d, mask_q, set_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[CMPL_BIT]  = set_cmpl;
        set_vec[ERR_BIT]   = set_err;
        set_vec[VSYNC_BIT] = set_vsync;
        sts_d  = (sts_q & ~(clr_we ? clr_data : '0)) | set_vec;
        mask_d = mask_we ? mask_data : mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q  <= '0;
            mask_q <= '1;
        end else begin
            sts_q  <= sts_d;
            mask_q <= mask_d;
        end
    end

    assign status = sts_q;
    assign irq    = |(sts_q & mask_q);
endmodule

// File: rtl/vdma_fetch.sv
module vdma_fetch
    import vdma_pkg::*;
#(
    parameter int CHANNEL = 2,
    parameter int FRAG_SZ = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              one_desc_i,
    input  logic              vsync_i,
    input  logic              sts_wr_i,
    input  logic [STS_W-1:0]  sts_wdata_i,
    input  logic              mask_wr_i,
    input  logic [STS_W-1:0]  mask_wdata_i,
    output logic              mem_req_o,
    output logic [1:0]        mem_op_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [LEN_W-1:0]  mem_len_o,
    output logic [DESC_W-1:0] mem_wdesc_o,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    input  logic [DESC_W-1:0] mem_rdesc_i,
    output logic [STS_W-1:0]  status_o,
    output logic              irq_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [TOT_W-1:0]  done_bytes_o
);
    localparam int FRAG_LG   = $clog2(FRAG_SZ);
    localparam int CMPL_BIT  = CHANNEL;
    localparam int ERR_BIT   = 12 + CHANNEL;
    localparam int VSYNC_BIT = 27;

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_MOVE, S_WBACK, S_WRAP} fsm_e;

    typedef struct packed {
        fsm_e              st;
        logic [ADDR_W-1:0] desc_addr;
        desc_t             desc;
        logic [ADDR_W-1:0] cur_addr;
        logic [LEN_W-1:0]  moved;
        logic [FIDX_W-1:0] idx;
        logic [TOT_W-1:0]  total;
        logic              one;
        logic              done;
        logic [TOT_W-1:0]  done_bytes;
    } regs_t;

    regs_t d, q;
    desc_t rdesc, wdesc;
    logic [ADDR_W-1:0] data_addr;
    logic [LEN_W-1:0]  remaining, chunk;
    logic              frag_end, move_end, set_err, set_cmpl;

    assign rdesc     = desc_t'(mem_rdesc_i);
    assign remaining = q.desc.xfer_len - q.moved;
    assign frag_end  = q.desc.flags.frag_f && (q.idx >= FIDX_W'(NFRAG));

    always_comb begin
        data_addr = q.cur_addr;
        if (q.desc.flags.frag_f)
            data_addr = frag_end ? '0 : q.desc.src[q.idx];
    end

    vdma_chunk_calc #(.FRAG_SZ(FRAG_SZ)) u_chunk (
        .frag_mode (q.desc.flags.frag_f),
        .addr_lo   (data_addr[FRAG_LG-1:0]),
        .line_size (q.desc.line_size),
        .remaining (remaining),
        .chunk     (chunk)
    );

    assign move_end = (remaining == '0) || (chunk == '0) || frag_end;

    always_comb begin
        wdesc              = q.desc;
        wdesc.flags.done_f = 1'b1;
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        set_err  = 1'b0;
        set_cmpl = 1'b0;
        unique case (q.st)
            S_IDLE: if (start_i) begin
                d.desc_addr = start_addr_i;
                d.one       = one_desc_i;
                d.total     = '0;
                d.st        = S_FETCH;
            end
            S_FETCH: if (mem_ack_i) begin
                if (mem_err_i) begin
                    set_err = 1'b1;
                    d.st = S_IDLE; d.done = 1'b1; d.done_bytes = '0;
                end else begin
                    d.desc     = rdesc;
                    d.moved    = '0;
                    d.idx      = '0;
                    d.cur_addr = rdesc.src[0];
                    d.st       = S_MOVE;
                end
            end
            S_MOVE: begin
                if (move_end) begin
                    d.st = q.desc.flags.upd_f ? S_WBACK : S_WRAP;
                end else if (mem_ack_i) begin
                    if (mem_err_i) begin
                        set_err = 1'b1;
                        d.st = S_IDLE; d.done = 1'b1; d.done_bytes = '0;
                    end else begin
                        d.moved    = q.moved + chunk;
                        d.total    = q.total + TOT_W'(chunk);
                        d.cur_addr = q.cur_addr + ADDR_W'(q.desc.stride);
                        d.idx      = q.idx + 1'b1;
                    end
                end
            end
            S_WBACK: if (mem_ack_i) begin
                if (mem_err_i) begin
                    set_err = 1'b1;
                    d.st = S_IDLE; d.done = 1'b1; d.done_bytes = '0;
                end else begin
                    d.st = S_WRAP;
                end
            end
            S_WRAP: begin
                set_cmpl = q.desc.flags.irq_f;
                if (q.desc.flags.last_f || q.one) begin
                    d.st = S_IDLE; d.done = 1'b1; d.done_bytes = q.total;
                end else begin
                    d.desc_addr = q.desc.next;
                    d.st        = S_FETCH;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_op_o    = OP_DESC_RD;
        mem_addr_o  = q.desc_addr;
        mem_len_o   = '0;
        mem_wdesc_o = wdesc;
        unique case (q.st)
            S_FETCH: mem_req_o = 1'b1;
            S_MOVE: begin
                mem_req_o  = !move_end;
                mem_op_o   = OP_DATA_RD;
                mem_addr_o = data_addr;
                mem_len_o  = chunk;
            end
            S_WBACK: begin
                mem_req_o = 1'b1;
                mem_op_o  = OP_DESC_WR;
            end
            default: ;
        endcase
    end

    vdma_irq_status #(
        .CMPL_BIT (CMPL_BIT),
        .ERR_BIT  (ERR_BIT),
        .VSYNC_BIT(VSYNC_BIT)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_cmpl (set_cmpl),
        .set_err  (set_err),
        .set_vsync(vsync_i),
        .clr_we   (sts_wr_i),
        .clr_data (sts_wdata_i),
        .mask_we  (mask_wr_i),
        .mask_data(mask_wdata_i),
        .status   (status_o),
        .irq      (irq_o)
    );

    assign busy_o       = (q.st != S_IDLE);
    assign done_o       = q.done;
    assign done_bytes_o = q.done_bytes;
endmodule

// File: rtl/vdma_fetch_chk.sv
module vdma_fetch_chk
    import vdma_pkg::*;
#(
    parameter int CHANNEL = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vsync_i,
    input logic              mem_req_o,
    input logic [1:0]        mem_op_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [LEN_W-1:0]  mem_len_o,
    input logic              mem_ack_i,
    input logic              mem_err_i,
    input logic [STS_W-1:0]  status_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [TOT_W-1:0]  done_bytes_o
);
    // R13: a waiting request keeps its op and address
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_op_o)));

    // R3: a data read never has zero length
    p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_op_o == 2'd1) |-> (mem_len_o != '0));

    // R6: a failed access sets the error bit and ends the run with zero bytes
    p_err_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && mem_err_i) |=> (status_o[12+CHANNEL] && done_o && done_bytes_o == '0));

    // R9: vsync always lands in the status register
    p_vsync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> status_o[27]);

    // R13: the done strobe comes when the engine has gone idle
    p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !mem_req_o));

    // R13: done is a single-cycle strobe unless the next run is also one cycle long (impossible)
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind vdma_fetch vdma_fetch_chk #(.CHANNEL(CHANNEL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_i     (vsync_i),
    .mem_req_o   (mem_req_o),
    .mem_op_o    (mem_op_o),
    .mem_addr_o  (mem_addr_o),
    .mem_len_o   (mem_len_o),
    .mem_ack_i   (mem_ack_i),
    .mem_err_i   (mem_err_i),
    .status_o    (status_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .done_bytes_o(done_bytes_o)
);

// File: tb/vdma_fetch_bench.sv
module vdma_fetch_bench;
    import vdma_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int CH = 2;

    logic clk = 0, rst_n = 0;
    logic start_i = 0, one_desc_i = 0, vsync_i = 0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic sts_wr_i = 0, mask_wr_i = 0;
    logic [STS_W-1:0] sts_wdata_i = '0, mask_wdata_i = '0;
    logic mem_req_o, mem_ack_i, mem_err_i;
    logic [1:0] mem_op_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [LEN_W-1:0] mem_len_o;
    logic [DESC_W-1:0] mem_wdesc_o, mem_rdesc_i;
    logic [STS_W-1:0] status_o;
    logic irq_o, busy_o, done_o;
    logic [TOT_W-1:0] done_bytes_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    vdma_fetch #(.CHANNEL(CH), .FRAG_SZ(4096)) u_vdma_fetch (.*);

    int total = 0, bad = 0;
    desc_t dmem [4];
    int err_at = -1, data_seen = 0;
    int nlog = 0;
    logic [1:0]        log_op   [64];
    logic [ADDR_W-1:0] log_addr [64];
    logic [LEN_W-1:0]  log_len  [64];
    int wb_cnt = 0;
    logic [ADDR_W-1:0] wb_addr;
    desc_t wb_desc;
    logic [TOT_W-1:0] last_bytes;

    assign mem_rdesc_i = dmem[mem_addr_o[9:8]];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack_i <= 0; mem_err_i <= 0;
        end else begin
            mem_ack_i <= mem_req_o && !mem_ack_i;
            mem_err_i <= mem_req_o && !mem_ack_i && mem_op_o == 2'd1 && data_seen == err_at;
            if (mem_req_o && mem_ack_i) begin
                if (nlog < 64) begin
                    log_op[nlog] <= mem_op_o; log_addr[nlog] <= mem_addr_o; log_len[nlog] <= mem_len_o;
                end
                nlog <= nlog + 1;
                if (mem_op_o == 2'd1) data_seen <= data_seen + 1;
                if (mem_op_o == 2'd2) begin
                    wb_cnt <= wb_cnt + 1; wb_addr <= mem_addr_o; wb_desc <= desc_t'(mem_wdesc_o);
                end
            end
        end
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic desc_t mk(input logic [4:0] fl, input int len, input int lsz, input int str,
                                 input logic [ADDR_W-1:0] s0, input logic [ADDR_W-1:0] s1,
                                 input logic [ADDR_W-1:0] s2, input logic [ADDR_W-1:0] s3,
                                 input logic [ADDR_W-1:0] s4, input logic [ADDR_W-1:0] nx);
        desc_t t;
        t.flags = dflags_t'(fl); t.xfer_len = LEN_W'(len); t.line_size = LEN_W'(lsz);
        t.stride = LEN_W'(str); t.src[0] = s0; t.src[1] = s1; t.src[2] = s2;
        t.src[3] = s3; t.src[4] = s4; t.next = nx;
        return t;
    endfunction

    task automatic run(input logic [ADDR_W-1:0] a, input logic one);
        int n = 0;
        @(negedge clk); start_i = 1; start_addr_i = a; one_desc_i = one;
        @(negedge clk); start_i = 0; one_desc_i = 0;
        while (!done_o && n < 2000) begin @(negedge clk); n++; end
        if (!done_o) check(0, "R13 timeout", 0, 1);
        last_bytes = done_bytes_o;
        @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); sts_wr_i = 1; sts_wdata_i = '1;
        @(negedge clk); sts_wr_i = 0; sts_wdata_i = '0;
    endtask

    task automatic expect_data(input int i, input logic [ADDR_W-1:0] a, input int l, input string r);
        check(log_op[i] == 2'd1, r, log_op[i], 1);
        check(log_addr[i] == a, r, log_addr[i], a);
        check(log_len[i] == LEN_W'(l), r, log_len[i], l);
    endtask

    task automatic t_reset();
        check(!mem_req_o && !busy_o && !done_o, "R1 idle", {mem_req_o, busy_o, done_o}, 0);
        check(status_o == 0, "R1 status", status_o, 0);
        check(!irq_o, "R1 irq", irq_o, 0);
    endtask

    task automatic t_line();
        int b = nlog, w = wb_cnt;
        dmem[0] = mk(5'b01110, 10, 4, 'h40, 'h8000, 0, 0, 0, 0, 0);
        run('h000, 0);
        check(nlog - b == 5, "R2 request count", nlog - b, 5);
        check(log_op[b] == 2'd0, "R2 desc read first", log_op[b], 0);
        expect_data(b+1, 'h8000, 4, "R2 line0");
        expect_data(b+2, 'h8040, 4, "R2 line1");
        expect_data(b+3, 'h8080, 2, "R3 last line cut");
        check(log_op[b+4] == 2'd2, "R7 write op", log_op[b+4], 2);
        check(wb_cnt == w + 1 && wb_addr == 'h000, "R7 wb addr", wb_addr, 0);
        check(wb_desc.flags.done_f == 1 && wb_desc.xfer_len == 10 && wb_desc.src[0] == 'h8000,
              "R7 wb content", wb_desc.flags, 5'b11110);
        check(status_o[CH] == 1, "R8 completion bit", status_o, 1 << CH);
        check(irq_o == 1, "R12 irq", irq_o, 1);
        check(last_bytes == 10, "R13 bytes", last_bytes, 10);
        clear_all();
        check(status_o == 0 && !irq_o, "R11 clear", status_o, 0);
    endtask

    task automatic t_zero();
        int b = nlog;
        dmem[0] = mk(5'b01000, 0, 4, 4, 'h8000, 0, 0, 0, 0, 0);
        run('h000, 0);
        check(nlog - b == 1, "R3 zero length no data", nlog - b, 1);
        check(last_bytes == 0, "R3 zero bytes", last_bytes, 0);
        check(status_o[CH] == 0, "R8 no completion without flag", status_o, 0);
    endtask

    task automatic t_frag();
        int b = nlog, w = wb_cnt;
        dmem[1] = mk(5'b01001, 5000, 0, 0, 'h0FF0, 'h2000, 'h3100, 'h9000, 'hA000, 0);
        run('h100, 0);
        check(nlog - b == 4, "R4 request count", nlog - b, 4);
        expect_data(b+1, 'h0FF0, 16, "R4 frag0");
        expect_data(b+2, 'h2000, 4096, "R4 frag1");
        expect_data(b+3, 'h3100, 888, "R3 frag cut");
        check(wb_cnt == w, "R7 no wb without flag", wb_cnt - w, 0);
        check(last_bytes == 5000, "R13 frag bytes", last_bytes, 5000);
    endtask

    task automatic t_five();
        int b = nlog;
        dmem[1] = mk(5'b01001, 30000, 0, 0, 'h1F00, 'h2F00, 'h3F00, 'h4F00, 'h5F00, 0);
        run('h100, 0);
        check(nlog - b == 6, "R5 five fragments only", nlog - b, 6);
        for (int i = 0; i < 5; i++) expect_data(b+1+i, 'h1F00 + i*'h1000, 256, "R5 frag");
        check(last_bytes == 1280, "R5 bytes", last_bytes, 1280);
    endtask

    task automatic t_err();
        int b = nlog, w = wb_cnt;
        clear_all();
        dmem[1] = mk(5'b01110, 12, 4, 4, 'h7000, 0, 0, 0, 0, 0);
        data_seen = 0; err_at = 1;
        run('h100, 0);
        err_at = -1;
        check(nlog - b == 3, "R6 stops at error", nlog - b, 3);
        check(status_o[12+CH] == 1, "R6 error bit", status_o, 1 << (12+CH));
        check(status_o[CH] == 0, "R6 no completion", status_o[CH], 0);
        check(wb_cnt == w, "R6 no write-back", wb_cnt - w, 0);
        check(last_bytes == 0, "R6 zero bytes", last_bytes, 0);
        clear_all();
    endtask

    task automatic t_chain();
        int b = nlog;
        dmem[2] = mk(5'b00000, 8, 8, 0, 'h4000, 0, 0, 0, 0, 'h300);
        dmem[3] = mk(5'b01001, 4, 0, 0, 'h0FFC, 0, 0, 0, 0, 0);
        run('h200, 0);
        check(nlog - b == 4, "R10 chain requests", nlog - b, 4);
        check(log_op[b+2] == 0 && log_addr[b+2] == 'h300, "R10 next desc", log_addr[b+2], 'h300);
        check(last_bytes == 12, "R10 chain bytes", last_bytes, 12);
        b = nlog;
        run('h200, 1);
        check(nlog - b == 2, "R10 one descriptor", nlog - b, 2);
        check(last_bytes == 8, "R10 one bytes", last_bytes, 8);
    endtask

    task automatic t_vsync();
        clear_all();
        @(negedge clk); mask_wr_i = 1; mask_wdata_i = ~(32'h1 << 27);
        @(negedge clk); mask_wr_i = 0; vsync_i = 1;
        @(negedge clk); vsync_i = 0;
        check(status_o[27] == 1, "R9 vsync bit", status_o, 32'h1 << 27);
        check(irq_o == 0, "R12 masked", irq_o, 0);
        @(negedge clk); mask_wr_i = 1; mask_wdata_i = '1;
        @(negedge clk); mask_wr_i = 0;
        check(irq_o == 1, "R12 unmasked", irq_o, 1);
        sts_wr_i = 1; sts_wdata_i = 32'h1 << 27;
        @(negedge clk); sts_wr_i = 0;
        check(status_o == 0 && !irq_o, "R11 w1c", status_o, 0);
        sts_wr_i = 1; sts_wdata_i = 32'h1 << 27; vsync_i = 1;
        @(negedge clk); sts_wr_i = 0; vsync_i = 0;
        check(status_o[27] == 1, "R11 set wins", status_o, 32'h1 << 27);
        clear_all();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_line();
        t_zero();
        t_frag();
        t_five();
        t_err();
        t_chain();
        t_vsync();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule